// File: doc/BRIEF.md
# Identification Tag Session Sequencer

This block is the control core of a wireless identification tag. It decides which message the tag sends, when it listens, and when it asks the random source and the crypto engine for work. A session opens with an uplink beacon. The reader then steers the tag's backscatter beam with adjust commands until it issues a trigger. The tag then collects random bytes for key setup, has the crypto engine build a commitment and sends it. It accepts the reader's challenge, has the engine build a response and sends that. The next session starts with a new beacon.

The downlink arrives as single bytes with a one-cycle valid strobe. The uplink is slow, so every outgoing message code is held on a valid/ready handshake for as long as the radio needs. Key bytes and challenge bytes go to the crypto engine through write strobes. The engine is started with a one-cycle pulse and a phase bit, and it reports completion with a done pulse. While the sequencer waits for the challenge, a watchdog with a programmable limit ends a stalled session and sends a beacon again.

Top module: `tag_session_seq`

## Requirements
- R1: After reset the first and only uplink activity is the beacon code 0xB1, offered with tx_valid high; beam_code resets to 0, and no random request or engine start occurs while in reset.
- R2: After the beacon is accepted, the opcode byte 0x01 followed by one payload byte sets beam_code to that payload byte in the cycle after the payload strobe; this may repeat any number of times.
- R3: Key setup starts only on the trigger opcode 0x02 received while beam tuning; beam adjust commands received after the trigger leave beam_code unchanged.
- R4: Key setup raises rng_req and performs exactly KEY_BYTES handshakes; each accepted rng_data byte appears on key_data with key_we high one cycle later. The engine is started (eng_start high, eng_phase 0) in the same cycle as the last key write, and not before.
- R5: The commitment code 0xC2 is offered on the uplink only after eng_done arrives for the commit phase, and no uplink activity occurs while the engine is busy.
- R6: After the commitment is accepted, opcode 0x03 followed by CHAL_BYTES payload bytes forwards each byte on chal_data with chal_we one cycle after its strobe. With the last byte the engine starts with eng_phase 1. After eng_done the response code 0xD3 is sent, and once it is accepted the beacon follows.
- R7: Opcodes other than 0x01, 0x02 and 0x03, and valid opcodes in a state that does not expect them, are ignored: the state, beam_code and the uplink are unchanged.
- R8: While waiting for the challenge, wd_limit consecutive cycles without a downlink strobe return the block to the beacon state, so 0xB1 is offered again. Any downlink byte restarts the count.
- R9: While tx_valid is high and tx_ready is low, tx_valid stays high and tx_data is unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_data | input | 8 | Downlink byte |
| rx_valid | input | 1 | One-cycle strobe for rx_data |
| tx_data | output | 8 | Uplink message code |
| tx_valid | output | 1 | Uplink code offered |
| tx_ready | input | 1 | Uplink accepts the code |
| rng_req | output | 1 | Random byte requested |
| rng_ack | input | 1 | Random byte present |
| rng_data | input | 8 | Random byte |
| key_data | output | 8 | Key byte to the crypto engine |
| key_we | output | 1 | Key byte write strobe |
| chal_data | output | 8 | Challenge byte to the crypto engine |
| chal_we | output | 1 | Challenge byte write strobe |
| eng_start | output | 1 | One-cycle crypto engine start |
| eng_phase | output | 1 | 0 = build commitment, 1 = build response |
| eng_done | input | 1 | Crypto engine finished |
| beam_code | output | BEAM_W | Current beam steering setting |
| wd_limit | input | WD_W | Silent cycles allowed while waiting for the challenge |

## Verification
The properties assume that rng_ack is raised only while rng_req is high, that eng_done pulses only while the engine is busy, that each downlink byte is a single-cycle strobe, and that wd_limit does not change during a session. The stimulus follows these rules. It answers random requests only after seeing rng_req, pulses eng_done once per start, and keeps downlink gaps well below wd_limit except in the directed timeout case. Random beam codes, key bytes, challenge bytes, handshake delays and stray opcodes vary the traffic within these limits.

// File: rtl/tag_seq_pkg.sv
`timescale 1ns/100ps
package tag_seq_pkg;

    localparam logic [7:0] OP_BEAM   = 8'h01;
    localparam logic [7:0] OP_TRIG   = 8'h02;
    localparam logic [7:0] OP_CHAL   = 8'h03;

    localparam logic [7:0] UP_BEACON = 8'hB1;
    localparam logic [7:0] UP_COMMIT = 8'hC2;
    localparam logic [7:0] UP_RESP   = 8'hD3;

    typedef enum logic [3:0] {
        S_BEACON, S_TUNE, S_KEYS, S_CSTART, S_CWAIT,
        S_COMMIT, S_CHAL, S_RSTART, S_RWAIT, S_RESP
    } state_t;

    typedef enum logic [1:0] { EV_NONE, EV_OP, EV_PAY } ev_kind_t;

    typedef struct packed {
        ev_kind_t   kind;
        logic [7:0] op;
        logic [7:0] data;
        logic       last;
    } rx_ev_t;

    // Number of payload bytes that follow an opcode.
    function automatic int unsigned pay_len(input logic [7:0] op,
                                            input int unsigned chal_len);
        case (op)
            OP_BEAM: return 1;
            OP_CHAL: return chal_len;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/tag_cmd_parse.sv
`timescale 1ns/100ps
module tag_cmd_parse
    import tag_seq_pkg::*;
#(
    parameter int CHAL_BYTES = 32
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic [7:0] rx_data,
    input  logic       rx_valid,
    output rx_ev_t     ev
);
    localparam int LW = (CHAL_BYTES > 1) ? $clog2(CHAL_BYTES) : 1;

    logic          in_frame;
    logic [7:0]    cur_op;
    logic [LW-1:0] left;

    always_comb begin
        ev      = '0;
        ev.kind = EV_NONE;
        if (rx_valid) begin
            ev.data = rx_data;
            if (in_frame) begin
                ev.kind = EV_PAY;
                ev.op   = cur_op;
                ev.last = (left == '0);
            end else begin
                ev.kind = EV_OP;
                ev.op   = rx_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            in_frame <= 1'b0;
            cur_op   <= '0;
            left     <= '0;
        end else if (rx_valid) begin
            if (in_frame) begin
                if (left == '0) in_frame <= 1'b0;
                else            left     <= left - 1'b1;
            end else if (pay_len(rx_data, CHAL_BYTES) != 0) begin
                in_frame <= 1'b1;
                cur_op   <= rx_data;
                left     <= LW'(pay_len(rx_data, CHAL_BYTES) - 1);
            end
        end
    end
endmodule

// File: rtl/tag_wdog.sv
`timescale 1ns/100ps
module tag_wdog #(
    parameter int WD_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic            kick,
    input  logic [WD_W-1:0] limit,
    output logic            fire
);
    logic [WD_W-1:0] cnt;
    logic [WD_W:0]   nxt;

    assign nxt  = {1'b0, cnt} + 1'b1;
    assign fire = en && !kick && (nxt >= {1'b0, limit});

    always_ff @(posedge clk) begin
        if (rst || !en || kick || fire) cnt <= '0;
        else                            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/tag_session_seq.sv
`timescale 1ns/100ps
module tag_session_seq
    import tag_seq_pkg::*;
#(
    parameter int BEAM_W     = 8,
    parameter int KEY_BYTES  = 32,
    parameter int CHAL_BYTES = 32,
    parameter int WD_W       = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        rx_data,
    input  logic              rx_valid,
    output logic [7:0]        tx_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic              rng_req,
    input  logic              rng_ack,
    input  logic [7:0]        rng_data,
    output logic [7:0]        key_data,
    output logic              key_we,
    output logic [7:0]        chal_data,
    output logic              chal_we,
    output logic              eng_start,
    output logic              eng_phase,
    input  logic              eng_done,
    output logic [BEAM_W-1:0] beam_code,
    input  logic [WD_W-1:0]   wd_limit
);
    localparam int KW = (KEY_BYTES > 1) ? $clog2(KEY_BYTES) : 1;

    state_t        state;
    rx_ev_t        ev;
    logic          wd_fire;
    logic          chal_armed;
    logic [KW-1:0] kcnt;

    tag_cmd_parse #(.CHAL_BYTES(CHAL_BYTES)) u_parse (
        .clk      (clk),
        .rst      (rst),
        .clr      (wd_fire),
        .rx_data  (rx_data),
        .rx_valid (rx_valid),
        .ev       (ev)
    );

    tag_wdog #(.WD_W(WD_W)) u_wdog (
        .clk   (clk),
        .rst   (rst),
        .en    (state == S_CHAL),
        .kick  (rx_valid),
        .limit (wd_limit),
        .fire  (wd_fire)
    );

    always_comb begin
        tx_valid = 1'b0;
        tx_data  = '0;
        case (state)
            S_BEACON: begin tx_valid = 1'b1; tx_data = UP_BEACON; end
            S_COMMIT: begin tx_valid = 1'b1; tx_data = UP_COMMIT; end
            S_RESP:   begin tx_valid = 1'b1; tx_data = UP_RESP;   end
            default:  ;
        endcase
    end

    assign rng_req   = (state == S_KEYS);
    assign eng_start = (state == S_CSTART) || (state == S_RSTART);
    assign eng_phase = (state == S_RSTART);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= S_BEACON;
            beam_code  <= '0;
            kcnt       <= '0;
            key_we     <= 1'b0;
            key_data   <= '0;
            chal_we    <= 1'b0;
            chal_data  <= '0;
            chal_armed <= 1'b0;
        end else begin
            key_we  <= 1'b0;
            chal_we <= 1'b0;
            case (state)
                S_BEACON: if (tx_ready) state <= S_TUNE;
                S_TUNE: begin
                    if (ev.kind == EV_PAY && ev.op == OP_BEAM)
                        beam_code <= BEAM_W'(ev.data);
                    else if (ev.kind == EV_OP && ev.op == OP_TRIG) begin
                        state <= S_KEYS;
                        kcnt  <= '0;
                    end
                end
                S_KEYS: if (rng_ack) begin
                    key_we   <= 1'b1;
                    key_data <= rng_data;
                    if (kcnt == KW'(KEY_BYTES - 1)) state <= S_CSTART;
                    else                            kcnt  <= kcnt + 1'b1;
                end
                S_CSTART: state <= S_CWAIT;
                S_CWAIT:  if (eng_done) state <= S_COMMIT;
                S_COMMIT: if (tx_ready) begin
                    state      <= S_CHAL;
                    chal_armed <= 1'b0;
                end
                S_CHAL: begin
                    if (wd_fire) state <= S_BEACON;
                    else if (ev.kind == EV_OP && ev.op == OP_CHAL)
                        chal_armed <= 1'b1;
                    else if (chal_armed && ev.kind == EV_PAY && ev.op == OP_CHAL) begin
                        chal_we   <= 1'b1;
                        chal_data <= ev.data;
                        if (ev.last) begin
                            state      <= S_RSTART;
                            chal_armed <= 1'b0;
                        end
                    end
                end
                S_RSTART: state <= S_RWAIT;
                S_RWAIT:  if (eng_done) state <= S_RESP;
                S_RESP:   if (tx_ready) state <= S_BEACON;
                default:  state <= S_BEACON;
            endcase
        end
    end
endmodule

// File: rtl/tag_session_seq_chk.sv
`timescale 1ns/100ps
module tag_session_seq_chk
    import tag_seq_pkg::*;
#(
    parameter int BEAM_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              rx_valid,
    input logic [7:0]        tx_data,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic              rng_req,
    input logic              rng_ack,
    input logic [7:0]        rng_data,
    input logic [7:0]        key_data,
    input logic              key_we,
    input logic              chal_we,
    input logic              eng_start,
    input logic              eng_phase,
    input logic              eng_done,
    input logic [BEAM_W-1:0] beam_code,
    input state_t            state,
    input logic              wd_fire
);
    // R1
    first_beacon_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> tx_valid && tx_data == UP_BEACON);

    // R2
    beam_after_rx_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(beam_code) |-> $past(rx_valid));

    // R3
    beam_only_tuning_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(beam_code) |-> $past(state) == S_TUNE);

    // R4
    key_copy_chk: assert property (@(posedge clk) disable iff (rst)
        (rng_req && rng_ack) |=> key_we && key_data == $past(rng_data));

    // R4
    commit_start_chk: assert property (@(posedge clk) disable iff (rst)
        (eng_start && !eng_phase) |-> key_we);

    // R4
    start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        eng_start |=> !eng_start);

    // R5
    commit_after_done_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_data == UP_COMMIT && !$past(tx_valid)) |-> $past(eng_done));

    // R6
    resp_start_chk: assert property (@(posedge clk) disable iff (rst)
        (eng_start && eng_phase) |-> chal_we);

    // R8
    wd_beacon_chk: assert property (@(posedge clk) disable iff (rst)
        wd_fire |=> tx_valid && tx_data == UP_BEACON);

    // R9
    tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> tx_valid && $stable(tx_data));

    // R4
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({key_we, chal_we, eng_done && eng_start}));
endmodule

bind tag_session_seq tag_session_seq_chk #(.BEAM_W(BEAM_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .rx_valid  (rx_valid),
    .tx_data   (tx_data),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .rng_req   (rng_req),
    .rng_ack   (rng_ack),
    .rng_data  (rng_data),
    .key_data  (key_data),
    .key_we    (key_we),
    .chal_we   (chal_we),
    .eng_start (eng_start),
    .eng_phase (eng_phase),
    .eng_done  (eng_done),
    .beam_code (beam_code),
    .state     (state),
    .wd_fire   (wd_fire)
);

// File: tb/tag_session_seq_test.sv
`timescale 1ns/100ps
module tag_session_seq_test;
    localparam int KEYS = 32;
    localparam int CHAL = 32;
    localparam int WDL  = 40;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] rx_data = '0;
    logic       rx_valid = 1'b0;
    logic [7:0] tx_data;
    logic       tx_valid;
    logic       tx_ready = 1'b0;
    logic       rng_req;
    logic       rng_ack = 1'b0;
    logic [7:0] rng_data = '0;
    logic [7:0] key_data;
    logic       key_we;
    logic [7:0] chal_data;
    logic       chal_we;
    logic       eng_start;
    logic       eng_phase;
    logic       eng_done = 1'b0;
    logic [7:0] beam_code;
    logic [15:0] wd_limit = 16'(WDL);

    int errors = 0;
    int checks = 0;
    logic [7:0] exp_beam = '0;

    always #2.5 clk = ~clk;

    tag_session_seq uut (
        .clk(clk), .rst(rst), .rx_data(rx_data), .rx_valid(rx_valid),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .rng_req(rng_req), .rng_ack(rng_ack), .rng_data(rng_data),
        .key_data(key_data), .key_we(key_we), .chal_data(chal_data),
        .chal_we(chal_we), .eng_start(eng_start), .eng_phase(eng_phase),
        .eng_done(eng_done), .beam_code(beam_code), .wd_limit(wd_limit)
    );

    function automatic logic [7:0] up_code(input int step);
        case (step)
            0: return 8'hB1;
            1: return 8'hC2;
            default: return 8'hD3;
        endcase
    endfunction

    function automatic logic [7:0] stray_op(input logic [7:0] r);
        return (r >= 8'h01 && r <= 8'h03) ? (r | 8'h40) : r;
    endfunction

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic send_raw(input logic [7:0] b);
        rx_data  = b;
        rx_valid = 1'b1;
        tick();
        rx_valid = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        send_raw(b);
        repeat ($urandom_range(1, 3)) tick();
    endtask

    task automatic wait_tx(input int step, input string req);
        int n = 0;
        while (!tx_valid && n < 200) begin tick(); n++; end
        chk(tx_valid && tx_data == up_code(step), req, "uplink code",
            {tx_valid, tx_data}, {1'b1, up_code(step)});
        repeat ($urandom_range(0, 3)) begin
            tick();
            chk(tx_valid && tx_data == up_code(step), "R9", "held code",
                {tx_valid, tx_data}, {1'b1, up_code(step)});
        end
        tx_ready = 1'b1;
        tick();
        tx_ready = 1'b0;
    endtask

    task automatic session(input bit timeout);
        logic [7:0] b;
        wait_tx(0, "R1");
        for (int i = 0; i < int'($urandom_range(1, 4)); i++) begin
            if ($urandom_range(0, 1) == 1) begin
                send_byte(stray_op(8'($urandom)));
                chk(beam_code == exp_beam && !tx_valid && !rng_req, "R7",
                    "stray op in tuning", beam_code, exp_beam);
            end
            exp_beam = 8'($urandom);
            send_byte(8'h01);
            send_raw(exp_beam);
            chk(beam_code == exp_beam, "R2", "beam update", beam_code, exp_beam);
            tick();
        end
        chk(!rng_req, "R3", "no key setup before trigger", rng_req, 0);
        send_byte(8'h02);
        chk(rng_req, "R3", "key setup after trigger", rng_req, 1);
        send_byte(8'h01);
        send_byte(~exp_beam);
        chk(beam_code == exp_beam, "R3", "beam frozen after trigger", beam_code, exp_beam);
        for (int i = 0; i < KEYS; i++) begin
            repeat ($urandom_range(0, 2)) tick();
            b = 8'($urandom);
            rng_ack = 1'b1;
            rng_data = b;
            tick();
            rng_ack = 1'b0;
            chk(key_we && key_data == b, "R4", "key byte", {key_we, key_data}, {1'b1, b});
            if (i < KEYS - 1)
                chk(!eng_start, "R4", "early start", eng_start, 0);
            else
                chk(eng_start && !eng_phase, "R4", "commit start",
                    {eng_start, eng_phase}, 2'b10);
        end
        repeat ($urandom_range(1, 5)) tick();
        chk(!tx_valid && !rng_req, "R5", "quiet while engine busy", tx_valid, 0);
        eng_done = 1'b1;
        tick();
        eng_done = 1'b0;
        wait_tx(1, "R5");
        if (timeout) begin
            repeat (WDL - 2) tick();
            send_raw(8'h77);
            repeat (WDL - 1) tick();
            chk(!tx_valid, "R8", "no timeout after restart", tx_valid, 0);
            tick();
            chk(tx_valid && tx_data == 8'hB1, "R8", "beacon after timeout",
                {tx_valid, tx_data}, 9'h1B1);
            return;
        end
        send_byte(stray_op(8'($urandom)));
        send_byte(8'h02);
        chk(!tx_valid && !eng_start && !chal_we, "R7", "stray op in challenge wait",
            {tx_valid, eng_start, chal_we}, 0);
        send_byte(8'h03);
        for (int i = 0; i < CHAL; i++) begin
            b = 8'($urandom);
            send_raw(b);
            chk(chal_we && chal_data == b, "R6", "challenge byte",
                {chal_we, chal_data}, {1'b1, b});
            if (i == CHAL - 1)
                chk(eng_start && eng_phase, "R6", "response start",
                    {eng_start, eng_phase}, 2'b11);
            else
                repeat ($urandom_range(0, 2)) tick();
        end
        repeat ($urandom_range(1, 4)) tick();
        chk(!tx_valid, "R6", "no response before done", tx_valid, 0);
        eng_done = 1'b1;
        tick();
        eng_done = 1'b0;
        wait_tx(2, "R6");
    endtask

    initial begin
        int unsigned seed_set;
        seed_set = $urandom(32'h5EED);
        repeat (3) tick();
        chk(beam_code == 0 && !rng_req && !eng_start && !key_we, "R1", "reset state",
            {beam_code, rng_req, eng_start, key_we}, 0);
        rst = 1'b0;
        tick();
        for (int s = 0; s < 3; s++) session(1'b0);
        session(1'b1);
        session(1'b0);
        wait_tx(0, "R6");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog run did not complete actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule